// File: doc/BRIEF.md
# Watchdog Countdown Timer with Register Bus

This block is a system watchdog. It sits on a simple 32-bit register bus with byte offsets and read data that is valid in the same cycle. A down-counter is loaded with a value fixed when the chip is built. Software starts the counter by setting the run bit in the control register. From then on the counter cannot be halted. It can only be pushed back to the full load value, and a write of any data to the low period register does that. This write is the kick.

If software fails to kick in time, the counter passes zero and the block drives `sysReset` high for a parameterised number of cycles. It sets a sticky timeout flag in the status register. It then reloads and counts again. If a kick and an expiry fall in the same cycle, the kick wins.

Word registers, by byte offset:

- 0x00 is status: bit 0 is the timeout flag, bit 1 is the running flag.
- 0x04 is control: bit 2 is the run bit.
- 0x08 is the low period register.
- 0x0C is the high period register.

Top module: `wdog_timer`

## Requirements
- R1: After reset `sysReset` is 0, the status register (offset 0x00) reads 0 and the control register (offset 0x04) reads 0. While the timer is stopped the counter holds LOAD_VALUE.
- R2: A control write with bit 2 set starts the timer, and control then reads 4. A control write with bit 2 clear leaves a stopped timer stopped.
- R3: Once running, the timer keeps running. No later control write, including one that clears bit 2, stops it or changes its expiry time.
- R4: The first expiry comes LOAD_VALUE+1 clock edges after the start write. `sysReset` is first high after clock edge LOAD_VALUE+1, counting the edge that takes the start write as edge 0.
- R5: `sysReset` stays high for exactly PULSE_LEN cycles. The counter reloads on expiry and keeps running, so the next expiry follows LOAD_VALUE+1 edges later.
- R6: A write of any data to offset 0x08 reloads the counter with LOAD_VALUE, so expiry moves to LOAD_VALUE+1 edges after the kick edge.
- R7: A kick taken on the same edge as an expiry wins. No reset pulse is issued and the timeout flag is not set.
- R8: Status bit 0 (timeout) is set on expiry and cleared by any write to offset 0x00. If expiry and the clearing write fall on the same edge, the set wins. Status bit 1 shows the running state.
- R9: Offset 0x08 reads the low 16 bits of LOAD_VALUE and offset 0x0C reads the high 16 bits. Writes to 0x0C change nothing, and in particular they do not kick. Offsets 0x10 and above read 0.
- R10: A kick while the timer is stopped does not start it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access valid this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W | Byte address of the access |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data for busAddr, combinational |
| sysReset | output | 1 | System reset pulse on expiry |

## Verification
The bench builds the block with LOAD_VALUE = 20 and PULSE_LEN = 3. With these values the bench can observe both a first and a second expiry edge for edge in a few dozen cycles, and the multi-cycle pulse branch is elaborated. The short load also lets a kick be placed on the exact cycle the counter sits at zero, and lets control writes land part way through a countdown. These values make the upper period half read zero, so that read only confirms the high-half mapping. The nonzero part of the mapping is exercised through the low half.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  // Word index of each register (byte offset >> 2)
  localparam logic [1:0] REG_STATUS    = 2'd0;
  localparam logic [1:0] REG_CONTROL   = 2'd1;
  localparam logic [1:0] REG_PERIOD_LO = 2'd2;
  localparam logic [1:0] REG_PERIOD_HI = 2'd3;

  // Bit positions software relies on
  localparam int CTRL_RUN_BIT    = 2;
  localparam int STAT_TIMEOUT_BIT = 0;
  localparam int STAT_RUN_BIT     = 1;

  // Strobes from control to datapath
  typedef struct packed {
    logic kick;   // reload counter with the load value
    logic run;    // counter is allowed to decrement
  } dpStrobe_t;

endpackage

// File: rtl/wdog_datapath.sv
module wdog_datapath
  import wdog_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter logic [DATA_W-1:0] LOAD_VALUE = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  output logic [DATA_W-1:0] count,
  output logic              wrap
);

  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic atZero;

  assign atZero = (count == '0);
  // Expiry only while running, and a kick in the same cycle suppresses it
  assign wrap   = strobe.run && atZero && !strobe.kick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= LOAD_VALUE;
    end else if (strobe.kick || wrap) begin
      count <= LOAD_VALUE;
    end else if (strobe.run) begin
      count <= count - ONE;
    end
  end

endmodule

// File: rtl/wdog_rstgen.sv
module wdog_rstgen #(
  parameter int PULSE_LEN = 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic trigger,
  output logic pulse
);

  generate
    if (PULSE_LEN <= 1) begin : g_single
      logic pulseQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) pulseQ <= 1'b0;
        else       pulseQ <= trigger;
      end
      assign pulse = pulseQ;
    end else begin : g_multi
      localparam int PW = $clog2(PULSE_LEN + 1);
      localparam logic [PW-1:0] LEN = PW'(PULSE_LEN);
      localparam logic [PW-1:0] ONE = PW'(1);
      logic [PW-1:0] remaining;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          remaining <= '0;
        end else if (trigger) begin
          remaining <= LEN;
        end else if (remaining != '0) begin
          remaining <= remaining - ONE;
        end
      end
      assign pulse = (remaining != '0);
    end
  endgenerate

endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter int              ADDR_W     = 5,
  parameter logic [DATA_W-1:0] LOAD_VALUE = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              wrap,
  output dpStrobe_t         strobe,
  output logic              running,
  output logic              timeoutFlag
);

  localparam int HALF_W = DATA_W / 2;

  logic       wrEn;
  logic       mapped;
  logic [1:0] regIdx;
  logic       startReq;
  logic       clearReq;

  assign wrEn   = busSel && busWrite;
  assign mapped = ((busAddr >> 4) == '0);
  assign regIdx = busAddr[3:2];

  assign startReq = wrEn && mapped && (regIdx == REG_CONTROL) && busWdata[CTRL_RUN_BIT];
  assign clearReq = wrEn && mapped && (regIdx == REG_STATUS);

  assign strobe.kick = wrEn && mapped && (regIdx == REG_PERIOD_LO);
  assign strobe.run  = running;

  // Run flag is sticky: only reset clears it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         running <= 1'b0;
    else if (startReq) running <= 1'b1;
  end

  // Timeout flag: expiry sets, status write clears, set wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         timeoutFlag <= 1'b0;
    else if (wrap)     timeoutFlag <= 1'b1;
    else if (clearReq) timeoutFlag <= 1'b0;
  end

  always_comb begin
    busRdata = '0;
    if (mapped) begin
      unique case (regIdx)
        REG_STATUS: begin
          busRdata[STAT_TIMEOUT_BIT] = timeoutFlag;
          busRdata[STAT_RUN_BIT]     = running;
        end
        REG_CONTROL:   busRdata[CTRL_RUN_BIT] = running;
        REG_PERIOD_LO: busRdata[HALF_W-1:0]   = LOAD_VALUE[HALF_W-1:0];
        REG_PERIOD_HI: busRdata[HALF_W-1:0]   = LOAD_VALUE[DATA_W-1:HALF_W];
        default:       busRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int              DATA_W     = 32,
  parameter int              ADDR_W     = 5,
  parameter logic [DATA_W-1:0] LOAD_VALUE = 32'd49_999_999,
  parameter int              PULSE_LEN  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              sysReset
);

  dpStrobe_t         strobe;
  logic [DATA_W-1:0] dpCount;
  logic              wrap;
  logic              running;
  logic              timeoutFlag;
  logic              kickSeen;

  assign kickSeen = strobe.kick;

  wdog_ctrl #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LOAD_VALUE(LOAD_VALUE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata),
    .wrap(wrap), .strobe(strobe),
    .running(running), .timeoutFlag(timeoutFlag)
  );

  wdog_datapath #(
    .DATA_W(DATA_W), .LOAD_VALUE(LOAD_VALUE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .count(dpCount), .wrap(wrap)
  );

  wdog_rstgen #(
    .PULSE_LEN(PULSE_LEN)
  ) u_rst (
    .clk(clk), .rstN(rstN), .trigger(wrap), .pulse(sysReset)
  );

endmodule

// File: rtl/wdog_timer_sva.sv
module wdog_timer_sva #(
  parameter int              DATA_W     = 32,
  parameter logic [DATA_W-1:0] LOAD_VALUE = '1
) (
  input logic              clk,
  input logic              rstN,
  input logic              running,
  input logic [DATA_W-1:0] count,
  input logic              kick,
  input logic              timeoutFlag,
  input logic              sysReset
);

  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  // R1: a stopped counter sits at the load value
  a_r1_idle_count: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> count == LOAD_VALUE);

  // R3: running never drops
  a_r3_run_sticky: assert property (@(posedge clk) disable iff (!rstN)
    running |=> running);

  // R4: one step down per cycle while running
  a_r4_countdown: assert property (@(posedge clk) disable iff (!rstN)
    (running && !kick && count != '0) |=> count == $past(count) - ONE);

  // R5: expiry reloads, raises the reset and the flag
  a_r5_expiry_reload: assert property (@(posedge clk) disable iff (!rstN)
    (running && !kick && count == '0) |=> (count == LOAD_VALUE && sysReset && timeoutFlag));

  // R5: a reset pulse only comes from a running timer
  a_r5_reset_while_running: assert property (@(posedge clk) disable iff (!rstN)
    sysReset |-> running);

  // R6: a kick reloads the counter
  a_r6_kick_reload: assert property (@(posedge clk) disable iff (!rstN)
    kick |=> count == LOAD_VALUE);

  // R7: kick on the zero cycle suppresses the timeout
  a_r7_kick_beats_expiry: assert property (@(posedge clk) disable iff (!rstN)
    (kick && running && count == '0) |=> !$rose(timeoutFlag));

endmodule

bind wdog_timer wdog_timer_sva #(
  .DATA_W(DATA_W), .LOAD_VALUE(LOAD_VALUE)
) u_sva (
  .clk(clk), .rstN(rstN), .running(running), .count(dpCount),
  .kick(kickSeen), .timeoutFlag(timeoutFlag), .sysReset(sysReset)
);

// File: tb/wdog_timer_tb.sv
module wdog_timer_tb;

  localparam int L  = 20;
  localparam int PL = 3;
  localparam logic [31:0] LOADV = 32'(L);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        sysReset;

  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  wdog_timer #(
    .DATA_W(32), .ADDR_W(5), .LOAD_VALUE(LOADV), .PULSE_LEN(PL)
  ) u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .sysReset(sysReset)
  );

  always #2 clk = ~clk;  // 250 MHz

  typedef struct packed {
    logic        isWrite;
    logic [4:0]  addr;
    logic [31:0] data;   // write data or expected read data
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 5'h00, 32'h0, 8'd1},            // R1 status after reset
    '{1'b0, 5'h04, 32'h0, 8'd1},            // R1 control after reset
    '{1'b0, 5'h08, LOADV & 32'hFFFF, 8'd9}, // R9 low half
    '{1'b0, 5'h0C, LOADV >> 16, 8'd9},      // R9 high half
    '{1'b0, 5'h10, 32'h0, 8'd9},            // R9 unmapped
    '{1'b0, 5'h1C, 32'h0, 8'd9},            // R9 unmapped
    '{1'b1, 5'h08, 32'h1234_5678, 8'd10},   // R10 kick while stopped
    '{1'b0, 5'h00, 32'h0, 8'd10},           // R10 still stopped
    '{1'b1, 5'h04, 32'h0000_0003, 8'd2},    // R2 write without run bit
    '{1'b0, 5'h00, 32'h0, 8'd2},
    '{1'b0, 5'h04, 32'h0, 8'd2},
    '{1'b1, 5'h0C, 32'hFFFF_FFFF, 8'd9}     // R9 high write ignored
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called at a negedge; write taken on the next posedge; returns at the following negedge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a;
    #1;
    d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    waitNeg(2);
    rstN = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    @(negedge clk);
    doReset();
    chk("R1 sysReset after reset", 32'(sysReset), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].isWrite) begin
        wr(VEC[i].addr, VEC[i].data);
      end else begin
        rd(VEC[i].addr, r);
        chk($sformatf("R%0d vector %0d", VEC[i].req, i), r, VEC[i].data);
      end
    end
    rd(5'h0C, r);
    chk("R9 high half after write", r, LOADV >> 16);
    waitNeg(L + 3);
    chk("R2 no reset without run bit", 32'(sysReset), 32'h0);
    chk("R10 no reset after stopped kick", 32'(sysReset), 32'h0);

    // R4, R5, R8: first expiry, pulse width, flag, reload
    doReset();
    wr(5'h04, 32'h4);
    rd(5'h04, r);
    chk("R2 control reads run", r, 32'h4);
    waitNeg(L);
    chk("R4 no reset before expiry", 32'(sysReset), 32'h0);
    waitNeg(1);
    chk("R4 reset at expiry", 32'(sysReset), 32'h1);
    rd(5'h00, r);
    chk("R8 status timeout+running", r, 32'h3);
    waitNeg(PL - 1);
    chk("R5 pulse last cycle", 32'(sysReset), 32'h1);
    waitNeg(1);
    chk("R5 pulse ended", 32'(sysReset), 32'h0);
    wr(5'h00, 32'h0);
    rd(5'h00, r);
    chk("R8 timeout cleared", r, 32'h2);
    waitNeg(L - PL - 1);
    chk("R5 no early second expiry", 32'(sysReset), 32'h0);
    waitNeg(1);
    chk("R5 second expiry", 32'(sysReset), 32'h1);

    // R3: control writes cannot stop
    doReset();
    wr(5'h04, 32'h4);
    waitNeg(5);
    wr(5'h04, 32'h0);
    rd(5'h00, r);
    chk("R3 still running", r, 32'h2);
    wr(5'h04, 32'hFFFF_FFFB);
    rd(5'h04, r);
    chk("R3 control still run", r, 32'h4);
    waitNeg(L - 7);
    chk("R3 schedule before expiry", 32'(sysReset), 32'h0);
    waitNeg(1);
    chk("R3 expiry on schedule", 32'(sysReset), 32'h1);

    // R6: kick with arbitrary data postpones expiry
    doReset();
    wr(5'h04, 32'h4);
    waitNeg(10);
    wr(5'h08, 32'hDEAD_BEEF);
    waitNeg(L);
    chk("R6 kick postponed expiry", 32'(sysReset), 32'h0);
    waitNeg(1);
    chk("R6 expiry after kick", 32'(sysReset), 32'h1);

    // R7: kick on the zero cycle wins
    doReset();
    wr(5'h04, 32'h4);
    waitNeg(L);
    wr(5'h08, 32'h0);
    chk("R7 no reset on tie", 32'(sysReset), 32'h0);
    rd(5'h00, r);
    chk("R7 no timeout flag", r, 32'h2);
    waitNeg(L);
    chk("R7 reload no early", 32'(sysReset), 32'h0);
    waitNeg(1);
    chk("R7 expiry after tie kick", 32'(sysReset), 32'h1);

    // R9: high period write is not a kick
    doReset();
    wr(5'h04, 32'h4);
    waitNeg(3);
    wr(5'h0C, 32'h0);
    rd(5'h08, r);
    chk("R9 low half running", r, LOADV & 32'hFFFF);
    waitNeg(L - 4);
    chk("R9 high write no kick pre", 32'(sysReset), 32'h0);
    waitNeg(1);
    chk("R9 high write no kick", 32'(sysReset), 32'h1);

    // R1: reset mid-pulse returns to idle
    doReset();
    chk("R1 sysReset cleared", 32'(sysReset), 32'h0);
    rd(5'h00, r);
    chk("R1 status cleared", r, 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule